// File: doc/BRIEF.md
# Fault-Aware Flit Serializer (Transmit Side)

This block sits at a router output port and drives a link that is divided into `NSEC` equal lanes of `SEC_W` bits each. A flit from the crossbar is cut into `NSEC` pieces of lane width. The pieces are placed only on lanes that the fault mask marks as healthy. When one flit runs out of pieces, the pieces of the following flit take the remaining healthy lanes of the same link word. No lane is left idle while data is waiting, so throughput drops in proportion to the number of faulty lanes.

A staging buffer holds up to two flits' worth of pieces. It is built from an upper half and a lower half that refill as they drain. The `take_o` output tells the crossbar whether a flit offered in the current cycle is accepted. Each piece carries the kind of its flit (head, body or tail) on a per-lane tag, so the receiver can rebuild flits and frame packets.

Top module: `flitser_tx`

## Requirements
- R1: A flit is split into `NSEC` pieces. The piece holding the most significant bits goes out first and the rest follow in descending order.
- R2: A lane whose bit in `lane_bad_i` is 1 never carries a piece. Its `link_vld_o` bit is 0, and its data and tag bits are 0.
- R3: In each link word, pieces fill the healthy lanes from the highest lane index downward, oldest piece first. The first piece of the next flit takes the next healthy lane in the same word.
- R4: With no faulty lane, a flit accepted in one cycle appears whole on `link_data_o` after the next clock edge, and `take_o` stays 1 for back-to-back flits.
- R5: With 4 lanes and three flits offered back to back from empty, the pieces occupy 4 link words with one faulty lane, 6 with two and 12 with three.
- R6: `take_o` is 0 whenever more than `NSEC` pieces are buffered. The buffer never holds more than `2*NSEC` pieces.
- R7: The fault mask is sampled only while the buffer is empty. A change to the mask while pieces are buffered has no effect until the buffer drains.
- R8: When every lane is faulty and the buffer is empty, `take_o` is 0 and no lane is valid.
- R9: Each valid lane carries the 2-bit kind of the flit its piece came from on `link_kind_o`: 0 idle, 1 head, 2 body, 3 tail.
- R10: A synchronous reset empties the buffer and clears `link_vld_o`. After reset, `take_o` is 1 if at least one lane is healthy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flit_i | input | NSEC*SEC_W | Flit from the crossbar |
| flit_vld_i | input | 1 | Flit offered this cycle |
| flit_kind_i | input | 2 | Kind of the offered flit |
| lane_bad_i | input | NSEC | Per-lane fault mask, 1 = unusable |
| take_o | output | 1 | Offered flit is accepted this cycle |
| link_data_o | output | NSEC*SEC_W | Link word, one piece per lane |
| link_vld_o | output | NSEC | Per-lane piece valid |
| link_kind_o | output | NSEC*2 | Per-lane flit kind tag |

## Verification
`take_o` is combinational from the buffer fill and the fault mask. It is therefore checked 1 ns after the inputs change, before the clock edge. The link word for that cycle is registered, so it is checked at the next falling edge, one edge after the stimulus. A queue model in the bench is written from the requirements. Each cycle it predicts acceptance and pops up to one piece per healthy lane, in the order that R3 sets. Directed scenarios cover the rate counts, a mask change in mid-stream, back-pressure and a fully faulty link, each with explicit checks at those cycle positions.

// File: rtl/flitser_pkg.sv
package flitser_pkg;
  localparam int KIND_W = 2;
  typedef enum logic [KIND_W-1:0] {
    FK_IDLE = 2'd0,
    FK_HEAD = 2'd1,
    FK_BODY = 2'd2,
    FK_TAIL = 2'd3
  } flit_kind_e;
endpackage

// File: rtl/flitser_slot_map.sv
// Ranks each healthy lane from the top: a lane's rank is the number of
// healthy lanes above it, i.e. the position in the pop order it receives.
module flitser_slot_map #(
  parameter int NSEC = 4,
  parameter int RW   = 4
) (
  input  logic [NSEC-1:0]    bad_i,
  output logic [NSEC*RW-1:0] rank_o,
  output logic [RW-1:0]      good_o
);
  always_comb begin
    logic [RW-1:0] acc;
    acc = '0;
    for (int s = NSEC - 1; s >= 0; s--) begin
      rank_o[s*RW +: RW] = acc;
      if (!bad_i[s]) acc = acc + 1'b1;
    end
    good_o = acc;
  end
endmodule

// File: rtl/flitser_queue.sv
// Piece buffer of two flits (upper and lower half). Presents a view of the
// buffered pieces followed by the incoming flit's pieces, then shifts out
// the popped ones.
module flitser_queue #(
  parameter int NSEC = 4,
  parameter int PW   = 10,
  parameter int CW   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   push_i,
  input  logic [NSEC*PW-1:0]     in_i,
  input  logic [CW-1:0]          pop_i,
  output logic [2*NSEC*PW-1:0]   view_o,
  output logic [CW-1:0]          avail_o,
  output logic [CW-1:0]          cnt_o
);
  localparam int DEPTH = 2 * NSEC;

  logic [PW-1:0] store [DEPTH];
  logic [CW-1:0] cnt;

  assign cnt_o   = cnt;
  assign avail_o = push_i ? cnt + CW'(NSEC) : cnt;

  genvar j;
  generate
    for (j = 0; j < DEPTH; j++) begin : g_view
      always_comb begin
        view_o[j*PW +: PW] = '0;
        if (CW'(j) < cnt) begin
          view_o[j*PW +: PW] = store[j];
        end else begin
          for (int i = 0; i < NSEC; i++) begin
            if (push_i && (int'(cnt) + i == j)) view_o[j*PW +: PW] = in_i[i*PW +: PW];
          end
        end
      end

      always_ff @(posedge clk) begin
        logic [PW-1:0] nxt;
        nxt = '0;
        for (int m = 0; m < DEPTH; m++) begin
          if (m == j + int'(pop_i)) nxt = view_o[m*PW +: PW];
        end
        store[j] <= nxt;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= avail_o - pop_i;
  end
endmodule

// File: rtl/flitser_tx.sv
module flitser_tx #(
  parameter int NSEC  = 4,
  parameter int SEC_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NSEC*SEC_W-1:0]                flit_i,
  input  logic                                 flit_vld_i,
  input  logic [flitser_pkg::KIND_W-1:0]       flit_kind_i,
  input  logic [NSEC-1:0]                      lane_bad_i,
  output logic                                 take_o,
  output logic [NSEC*SEC_W-1:0]                link_data_o,
  output logic [NSEC-1:0]                      link_vld_o,
  output logic [NSEC*flitser_pkg::KIND_W-1:0]  link_kind_o
);
  import flitser_pkg::*;

  localparam int PW    = SEC_W + KIND_W;
  localparam int DEPTH = 2 * NSEC;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [NSEC-1:0]       flt_q, flt_eff;
  logic [CW-1:0]         cnt, avail, good, pop;
  logic [NSEC*CW-1:0]    rank;
  logic [NSEC*PW-1:0]    in_pieces;
  logic [DEPTH*PW-1:0]   view;
  logic                  push;

  // mask is frozen while pieces are buffered
  assign flt_eff = (cnt == '0) ? lane_bad_i : flt_q;
  assign take_o  = (good != '0) && (cnt <= CW'(NSEC));
  assign push    = flit_vld_i && take_o;
  assign pop     = (good < avail) ? good : avail;

  genvar i;
  generate
    for (i = 0; i < NSEC; i++) begin : g_cut
      // piece 0 in pop order is the most significant slice
      assign in_pieces[i*PW +: PW] = {flit_kind_i, flit_i[(NSEC-1-i)*SEC_W +: SEC_W]};
    end
  endgenerate

  flitser_slot_map #(.NSEC(NSEC), .RW(CW)) u_map (
    .bad_i  (flt_eff),
    .rank_o (rank),
    .good_o (good)
  );

  flitser_queue #(.NSEC(NSEC), .PW(PW), .CW(CW)) u_queue (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push),
    .in_i    (in_pieces),
    .pop_i   (pop),
    .view_o  (view),
    .avail_o (avail),
    .cnt_o   (cnt)
  );

  logic [NSEC-1:0]        nxt_vld;
  logic [NSEC*SEC_W-1:0]  nxt_data;
  logic [NSEC*KIND_W-1:0] nxt_kind;

  generate
    for (i = 0; i < NSEC; i++) begin : g_lane
      always_comb begin
        logic [PW-1:0] pc;
        pc = '0;
        nxt_vld[i] = !flt_eff[i] && (rank[i*CW +: CW] < avail);
        for (int m = 0; m < DEPTH; m++) begin
          if (CW'(m) == rank[i*CW +: CW]) pc = view[m*PW +: PW];
        end
        if (!nxt_vld[i]) pc = '0;
        nxt_data[i*SEC_W +: SEC_W]   = pc[SEC_W-1:0];
        nxt_kind[i*KIND_W +: KIND_W] = pc[PW-1:SEC_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_q       <= '0;
      link_vld_o  <= '0;
      link_data_o <= '0;
      link_kind_o <= '0;
    end else begin
      flt_q       <= flt_eff;
      link_vld_o  <= nxt_vld;
      link_data_o <= nxt_data;
      link_kind_o <= nxt_kind;
    end
  end
endmodule

// File: rtl/flitser_chk.sv
module flitser_chk #(
  parameter int NSEC = 4,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [NSEC-1:0] lane_bad_i,
  input logic            flit_vld_i,
  input logic            take_o,
  input logic [NSEC-1:0] link_vld_o,
  input logic [CW-1:0]   cnt,
  input logic [CW-1:0]   avail,
  input logic [CW-1:0]   good,
  input logic [NSEC-1:0] flt_eff
);
  p_accept_room_r6: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (cnt <= CW'(NSEC)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(2 * NSEC));

  p_skip_faulty_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((link_vld_o & $past(flt_eff)) == '0));

  p_pack_bound_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($countones(link_vld_o) <= int'($past(good))) &&
              ($countones(link_vld_o) <= int'($past(avail)))));

  p_dead_link_r8: assert property (@(posedge clk) disable iff (rst)
    ((&lane_bad_i) && (cnt == '0)) |-> !take_o);

  p_clean_full_r4: assert property (@(posedge clk) disable iff (rst)
    ((lane_bad_i == '0) && (cnt == '0) && flit_vld_i) |=> (&link_vld_o));
endmodule

bind flitser_tx flitser_chk #(.NSEC(NSEC), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lane_bad_i (lane_bad_i),
  .flit_vld_i (flit_vld_i),
  .take_o     (take_o),
  .link_vld_o (link_vld_o),
  .cnt        (cnt),
  .avail      (avail),
  .good       (good),
  .flt_eff    (flt_eff)
);

// File: tb/test_flitser_tx.sv
module test_flitser_tx;
  localparam int NSEC = 4;
  localparam int SW   = 8;
  localparam int FW   = NSEC * SW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst;
  logic [FW-1:0] flit;
  logic          fv;
  logic [1:0]    fk;
  logic [3:0]    bad;
  logic          take;
  logic [FW-1:0] ldata;
  logic [3:0]    lvld;
  logic [7:0]    lkind;

  flitser_tx #(.NSEC(NSEC), .SEC_W(SW)) i_flitser_tx (
    .clk(clk), .rst(rst), .flit_i(flit), .flit_vld_i(fv), .flit_kind_i(fk),
    .lane_bad_i(bad), .take_o(take), .link_data_o(ldata), .link_vld_o(lvld),
    .link_kind_o(lkind)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [9:0] mq[$];
  logic [3:0] mflt;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // one cycle: drive, check acceptance before the edge, check link word after it
  task automatic step(input bit v, input logic [31:0] d, input logic [1:0] k,
                      input string req, output bit took);
    logic [3:0] eff;
    int         good;
    bit         ea;
    logic [31:0] ed;
    logic [3:0]  ev;
    logic [7:0]  ek;
    fv = v; flit = d; fk = k;
    #1;
    eff  = (mq.size() == 0) ? bad : mflt;
    good = 0;
    for (int s = 0; s < 4; s++) if (!eff[s]) good++;
    ea = (good > 0) && (mq.size() <= NSEC);
    chk(take === ea, {req, " take"}, take, ea);
    took = v && ea;
    if (took) for (int i = 0; i < 4; i++) mq.push_back({k, d[(3-i)*8 +: 8]});
    ed = '0; ev = '0; ek = '0;
    for (int s = 3; s >= 0; s--) begin
      if (!eff[s] && mq.size() > 0) begin
        logic [9:0] p;
        p = mq.pop_front();
        ev[s] = 1'b1;
        ed[s*8 +: 8] = p[7:0];
        ek[s*2 +: 2] = p[9:8];
      end
    end
    mflt = eff;
    @(posedge clk);
    @(negedge clk);
    chk(lvld === ev,  {req, " vld"},  lvld,  ev);
    chk(ldata === ed, {req, " data"}, ldata, ed);
    chk(lkind === ek, {req, " kind"}, lkind, ek);
  endtask

  task automatic do_reset(input logic [3:0] f);
    rst = 1'b1; fv = 1'b0; flit = '0; fk = '0; bad = f;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mq.delete();
    mflt = '0;
  endtask

  task automatic t_reset();
    do_reset(4'b0000);
    #1;
    chk(lvld === 4'b0, "R10 vld after reset", lvld, 0);
    chk(take === 1'b1, "R10 take after reset", take, 1);
  endtask

  task automatic t_clean();
    bit took;
    logic [31:0] d;
    do_reset(4'b0000);
    for (int n = 0; n < 4; n++) begin
      d = 32'hA1B2C3D4 + 32'h01010101 * n;
      step(1'b1, d, 2'd2, "R4 R1 clean", took);
      chk(took, "R4 back-to-back take", took, 1);
      chk(ldata === d, "R4 R1 whole flit", ldata, d);
    end
  endtask

  task automatic t_rate(input logic [3:0] f, input int expw, input string req);
    bit took;
    int sent  = 0;
    int words = 0;
    do_reset(f);
    while (sent < 3) begin
      step(1'b1, 32'h11223344 + 32'h10101010 * sent, 2'd2, req, took);
      if (took) sent++;
      if (lvld != 0) words++;
    end
    while (mq.size() > 0) begin
      step(1'b0, '0, 2'd0, req, took);
      if (lvld != 0) words++;
    end
    chk(words == expw, {req, " word count"}, words, expw);
  endtask

  task automatic t_kinds();
    bit took;
    logic [31:0] d1 = 32'hC0C1C2C3;
    logic [31:0] d2 = 32'hD0D1D2D3;
    logic [31:0] e;
    do_reset(4'b0010);
    step(1'b1, d1, 2'd1, "R9 head", took);
    chk(lkind === 8'h51, "R9 head tags", lkind, 8'h51);
    step(1'b1, d2, 2'd2, "R3 R9 body", took);
    e = {8'hC3, 8'hD0, 8'h00, 8'hD1};
    chk(ldata === e, "R3 fill leftover lanes", ldata, e);
    chk(lkind === 8'h62, "R3 R9 mixed tags", lkind, 8'h62);
    step(1'b1, 32'hE0E1E2E3, 2'd3, "R9 tail", took);
    while (mq.size() > 0) step(1'b0, '0, 2'd0, "R9 drain", took);
  endtask

  task automatic t_hold();
    bit took;
    do_reset(4'b0001);
    step(1'b1, 32'h01020304, 2'd1, "R7 first", took);
    bad = 4'b1100;
    step(1'b1, 32'h05060708, 2'd2, "R7 changed mask", took);
    chk(lvld === 4'b1110, "R7 old mask held", lvld, 4'b1110);
    while (mq.size() > 0) step(1'b0, '0, 2'd0, "R7 drain", took);
    step(1'b1, 32'h090A0B0C, 2'd3, "R7 new mask", took);
    chk(lvld === 4'b0011, "R7 new mask after drain", lvld, 4'b0011);
    while (mq.size() > 0) step(1'b0, '0, 2'd0, "R7 drain2", took);
  endtask

  task automatic t_backpressure();
    bit took;
    do_reset(4'b0111);
    step(1'b1, 32'hAAAAAAA1, 2'd1, "R6 f1", took);
    step(1'b1, 32'hAAAAAAA2, 2'd2, "R6 f2", took);
    step(1'b1, 32'hAAAAAAA3, 2'd3, "R6 f3", took);
    chk(!took, "R6 stall when full", took, 0);
    while (mq.size() > 0) step(1'b0, '0, 2'd0, "R6 drain", took);
  endtask

  task automatic t_dead();
    bit took;
    do_reset(4'b1111);
    for (int n = 0; n < 3; n++) begin
      step(1'b1, 32'hDEAD0000 + n, 2'd1, "R8 dead link", took);
      chk(!took, "R8 no accept", took, 0);
      chk(lvld === 4'b0, "R8 R2 nothing sent", lvld, 0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_clean();
    t_rate(4'b0010, 4,  "R5 one fault");
    t_rate(4'b1001, 6,  "R5 two faults");
    t_rate(4'b0111, 12, "R5 three faults");
    t_kinds();
    t_hold();
    t_backpressure();
    t_dead();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule